// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Select Line

This block is a full-duplex serial shifter for a synchronous clock-and-data link. A role input picks the side of the link. As bus master it produces the serial clock from the system clock and exchanges one byte per transfer. As bus slave it follows a serial clock driven by another device. Every pin it drives has its own output-enable, so the pads can be tri-stated.

When the select function is enabled, an active-low select input changes what the block does. A master treats a low on that line as a bus conflict. It latches an error flag, abandons the byte in flight and releases its clock and data pins. Software may clear the flag only once the line has returned high. A slave listens to its clock pin and drives its data pin only while it is selected. While it is deselected, clock edges on its input leave it untouched.

Each completed byte raises a one-cycle completion pulse that serves as the interrupt. In that handler, software can read the received byte and the error flag.

Top module: `sync_ser_port`

## Requirements
- R1: After reset the error flag, the completion pulse, the received byte and the clock output are all 0, and the master's clock and data enables are 1 when the role input is 1.
- R2: With the role input at 1, a start pulse sends tx_data_i most significant bit first over 8 clock periods. The clock idles low and each half period lasts HALF_DIV system cycles. The data output changes on falling clock edges. The data input is sampled on rising edges. The captured byte appears on rx_data_o.
- R3: With the select enable at 0, the select input has no effect: a master latches no error and a slave transfers with the line high.
- R4: A master with select enabled sets the error flag within 3 cycles of the select line going low, and drops both sck_oe_o and sd_out_oe_o while the flag is set.
- R5: A clear pulse removes the error flag only while the synchronised select line is high. After the clear, both enables return to 1.
- R6: A byte interrupted by a fault gives no completion pulse. The next transfer starts again from its first bit and delivers a full byte.
- R7: A start pulse that arrives while the error flag is set is ignored, and no clock is produced afterwards.
- R8: With the role input at 0, sck_oe_o stays 0. A selected slave samples sd_in_i on rising sck_i edges, shifts sd_out_o on falling edges, and completes after 8 falling edges.
- R9: A slave with select enabled and the select line high keeps sd_out_oe_o at 0 and ignores sck_i edges, so neither its bit count nor its shift register changes.
- R10: done_irq_o is high for exactly one cycle per completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_master_i | input | 1 | Role: 1 master, 0 slave |
| ctl_sel_en_i | input | 1 | Enables the select-line function |
| err_clr_i | input | 1 | Software clear of the error flag (pulse) |
| tx_data_i | input | DATA_W | Byte to send |
| tx_start_i | input | 1 | Master: start a transfer; slave: load the shift register |
| rx_data_o | output | DATA_W | Last received byte |
| done_irq_o | output | 1 | One-cycle transfer-complete interrupt |
| err_flag_o | output | 1 | Latched mode-fault flag |
| sel_ni | input | 1 | Select line, active low |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Clock pin output enable |
| sd_in_i | input | 1 | Serial data in |
| sd_out_o | output | 1 | Serial data out |
| sd_out_oe_o | output | 1 | Data pin output enable |

## Verification
A fault latch stuck in the wrong state shows at the enables within three cycles of the select line changing. It also shows as a missing or unexpected completion pulse. A bit counter that is off, or that counts while the slave is deselected, fires the completion early. The scoreboard then reads a byte mixed from two transfers, about one serial half period after the error. A wrong shift direction or sample edge corrupts the first byte compared, and the bench checks the master's outgoing bits on every rising clock edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   typedef enum logic {
      ROLE_SLAVE  = 1'b0,
      ROLE_MASTER = 1'b1
   } role_e;

   // counter width able to hold values 0 .. v-1, never below one bit
   function automatic int unsigned cnt_w(input int unsigned v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ssp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[g] <= RST_VAL;
            else         chain_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[g] <= RST_VAL;
            else         chain_q[g] <= chain_q[g-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ssp_sck_gen.sv
module ssp_sck_gen #(
   parameter int unsigned HALF_DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic sck_o,
   output logic rise_o,
   output logic fall_o
);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("ssp_sck_gen: HALF_DIV must be at least 1");
   end

   localparam int unsigned CW = ssp_pkg::cnt_w(HALF_DIV);
   localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;
   logic          sck_q;
   logic          tick;

   assign tick = run_i && (cnt_q == CNT_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sck_o  = sck_q;
   assign rise_o = tick && !sck_q;
   assign fall_o = tick &&  sck_q;

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              abort_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              last_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rx_o
);

   if (DATA_W < 2) begin : g_bad_width
      $error("ssp_shifter: DATA_W must be at least 2");
   end

   localparam int unsigned BW = ssp_pkg::cnt_w(DATA_W);
   localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] sh_next;
   logic [BW-1:0]     bit_q;
   logic              samp_q;
   logic              done_q;

   if (MSB_FIRST) begin : g_msb
      assign sh_next = {sh_q[DATA_W-2:0], samp_q};
      assign sdo_o   = sh_q[DATA_W-1];
   end else begin : g_lsb
      assign sh_next = {samp_q, sh_q[DATA_W-1:1]};
      assign sdo_o   = sh_q[0];
   end

   assign last_o = (bit_q == BIT_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
         samp_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort_i) begin
            bit_q <= '0;
         end else if (load_i) begin
            sh_q  <= load_data_i;
            bit_q <= '0;
         end else begin
            if (rise_i) samp_q <= sdi_i;
            if (fall_i) begin
               sh_q <= sh_next;
               if (last_o) begin
                  bit_q  <= '0;
                  rx_q   <= sh_next;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign done_o = done_q;
   assign rx_o   = rx_q;

endmodule

// File: rtl/ssp_sel_ctl.sv
module ssp_sel_ctl #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic master_i,
   input  logic sel_en_i,
   input  logic sel_ni,
   input  logic err_clr_i,
   output logic err_o,
   output logic fault_o,
   output logic slave_active_o
);

   logic sel_hi;
   logic fault_now;
   logic err_q;

   ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sel_ni),
      .q_o    (sel_hi)
   );

   assign fault_now = master_i && sel_en_i && !sel_hi;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  err_q <= 1'b0;
      else if (fault_now)           err_q <= 1'b1;
      else if (err_clr_i && sel_hi) err_q <= 1'b0;
   end

   assign err_o          = err_q;
   assign fault_o        = fault_now || err_q;
   assign slave_active_o = !sel_en_i || !sel_hi;

endmodule

// File: rtl/sync_ser_port.sv
module sync_ser_port #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned HALF_DIV    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ctl_master_i,
   input  logic              ctl_sel_en_i,
   input  logic              err_clr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_start_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              done_irq_o,
   output logic              err_flag_o,
   input  logic              sel_ni,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe_o,
   input  logic              sd_in_i,
   output logic              sd_out_o,
   output logic              sd_out_oe_o
);

   import ssp_pkg::*;

   role_e role;
   logic  is_master;
   logic  err_q, fault, slave_active;
   logic  sck_s, sck_d, sdi_s;
   logic  s_rise, s_fall, m_rise, m_fall;
   logic  busy_q, run, m_start, load;
   logic  last_bit, done;

   assign role      = role_e'(ctl_master_i);
   assign is_master = (role == ROLE_MASTER);

   ssp_sel_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .master_i       (is_master),
      .sel_en_i       (ctl_sel_en_i),
      .sel_ni         (sel_ni),
      .err_clr_i      (err_clr_i),
      .err_o          (err_q),
      .fault_o        (fault),
      .slave_active_o (slave_active)
   );

   ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sck_i), .q_o (sck_s)
   );

   ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sd_in_i), .q_o (sdi_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sck_d <= 1'b0;
      else         sck_d <= sck_s;
   end

   assign s_rise = !is_master && slave_active &&  sck_s && !sck_d;
   assign s_fall = !is_master && slave_active && !sck_s &&  sck_d;

   assign m_start = tx_start_i && is_master && !fault && !busy_q;
   assign load    = m_start || (tx_start_i && !is_master);
   assign run     = busy_q && !fault;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      busy_q <= 1'b0;
      else if (!is_master || fault)     busy_q <= 1'b0;
      else if (m_start)                 busy_q <= 1'b1;
      else if (m_fall && last_bit)      busy_q <= 1'b0;
   end

   ssp_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck_gen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .sck_o  (sck_o),
      .rise_o (m_rise),
      .fall_o (m_fall)
   );

   ssp_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .load_data_i (tx_data_i),
      .rise_i      (is_master ? m_rise : s_rise),
      .fall_i      (is_master ? m_fall : s_fall),
      .abort_i     (is_master && fault),
      .sdi_i       (sdi_s),
      .sdo_o       (sd_out_o),
      .last_o      (last_bit),
      .done_o      (done),
      .rx_o        (rx_data_o)
   );

   assign done_irq_o  = done;
   assign err_flag_o  = err_q;
   assign sck_oe_o    = is_master && !err_q;
   assign sd_out_oe_o = is_master ? !err_q : slave_active;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic ctl_master_i,
   input logic ctl_sel_en_i,
   input logic err_clr_i,
   input logic done_irq_o,
   input logic err_flag_o,
   input logic sck_oe_o,
   input logic sd_out_oe_o
);

   // R4: a latched fault in master role releases both pins
   a_r4_fault_releases_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_flag_o && ctl_master_i) |-> (!sck_oe_o && !sd_out_oe_o));

   // R5: the flag only falls after a clear request
   a_r5_clear_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(err_flag_o) |-> $past(err_clr_i));

   // R3: a fault can only appear with select enabled in master role
   a_r3_fault_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_flag_o) |-> $past(ctl_sel_en_i && ctl_master_i));

   // R8: a slave never drives the clock pin
   a_r8_slave_clock_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl_master_i |-> !sck_oe_o);

   // R10: completion is a single-cycle pulse
   a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_irq_o |=> !done_irq_o);

   // R6: no completion while a master fault is latched
   a_r6_no_done_in_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_flag_o && ctl_master_i) |-> !done_irq_o);

endmodule

bind sync_ser_port ssp_checker u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .ctl_master_i (ctl_master_i),
   .ctl_sel_en_i (ctl_sel_en_i),
   .err_clr_i    (err_clr_i),
   .done_irq_o   (done_irq_o),
   .err_flag_o   (err_flag_o),
   .sck_oe_o     (sck_oe_o),
   .sd_out_oe_o  (sd_out_oe_o)
);

// File: tb/sync_ser_port_tb_top.sv
module sync_ser_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ctl_master, ctl_sel_en, err_clr, tx_start;
   logic [7:0] tx_data;
   logic [7:0] rx_data;
   logic       done_irq, err_flag;
   logic       sel_n, sck_in, sck_out, sck_oe, sd_in, sd_out, sd_out_oe;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   logic prev_done = 1'b0;

   always #5 clk = ~clk;

   sync_ser_port dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ctl_master_i(ctl_master), .ctl_sel_en_i(ctl_sel_en),
      .err_clr_i(err_clr), .tx_data_i(tx_data), .tx_start_i(tx_start),
      .rx_data_o(rx_data), .done_irq_o(done_irq), .err_flag_o(err_flag),
      .sel_ni(sel_n), .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
      .sd_in_i(sd_in), .sd_out_o(sd_out), .sd_out_oe_o(sd_out_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every completion pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_irq && prev_done)
            chk(1'b0, "R10 pulse longer than one cycle", 32'd1, 32'd0);
         if (done_irq) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected completion", {24'd0, rx_data}, 32'd0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rx_data == e, "R2/R8 received byte", {24'd0, rx_data}, {24'd0, e});
            end
         end
         prev_done = done_irq;
      end
   end

   task automatic pulse_start(input logic [7:0] d);
      @(negedge clk); tx_data = d; tx_start = 1'b1;
      @(negedge clk); tx_start = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   task automatic m_xfer(input logic [7:0] tx, input logic [7:0] rxb);
      logic [7:0] seen;
      seen = '0;
      exp_q.push_back(rxb);
      @(negedge clk); sd_in = rxb[7]; tx_data = tx; tx_start = 1'b1;
      @(negedge clk); tx_start = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         @(posedge sck_out); #1;
         seen[i] = sd_out;
         @(negedge sck_out); @(negedge clk);
         if (i > 0) sd_in = rxb[i-1];
      end
      chk(seen == tx, "R2 master serial output MSB first", {24'd0, seen}, {24'd0, tx});
      repeat (6) @(negedge clk);
   endtask

   task automatic s_xfer(input logic [7:0] tx, input logic [7:0] rxb, input bit do_load);
      logic [7:0] seen;
      seen = '0;
      exp_q.push_back(rxb);
      if (do_load) pulse_start(tx);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk); sd_in = rxb[i];
         repeat (8) @(negedge clk);
         seen[i] = sd_out;
         sck_in = 1'b1;
         repeat (8) @(negedge clk);
         sck_in = 1'b0;
      end
      repeat (8) @(negedge clk);
      chk(seen == tx, "R8 slave serial output", {24'd0, seen}, {24'd0, tx});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ctl_master = 1'b1; ctl_sel_en = 1'b0; err_clr = 1'b0;
      tx_start = 1'b0; tx_data = '0; sel_n = 1'b1; sck_in = 1'b0; sd_in = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(err_flag == 1'b0, "R1 error flag", {31'd0, err_flag}, 32'd0);
      chk(done_irq == 1'b0, "R1 completion", {31'd0, done_irq}, 32'd0);
      chk(rx_data == 8'h00, "R1 received byte", {24'd0, rx_data}, 32'd0);
      chk(sck_out == 1'b0, "R1 clock idle", {31'd0, sck_out}, 32'd0);
      chk(sck_oe && sd_out_oe, "R1 master enables", {30'd0, sck_oe, sd_out_oe}, 32'd3);

      // R2 master transfers
      m_xfer(8'hA5, 8'h3C);
      m_xfer(8'h81, 8'h7E);
      m_xfer(8'h00, 8'hFF);

      // R3 select disabled: low select line is harmless
      sel_n = 1'b0;
      m_xfer(8'hC3, 8'h5A);
      chk(err_flag == 1'b0, "R3 no fault with select disabled", {31'd0, err_flag}, 32'd0);
      sel_n = 1'b1;
      repeat (4) @(negedge clk);

      // R4 fault in the middle of a byte
      ctl_sel_en = 1'b1;
      repeat (4) @(negedge clk);
      pulse_start(8'h55);
      repeat (3) @(posedge sck_out);
      @(negedge clk); sel_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(err_flag == 1'b1, "R4 fault latched", {31'd0, err_flag}, 32'd1);
      chk(sck_oe == 1'b0, "R4 clock released", {31'd0, sck_oe}, 32'd0);
      chk(sd_out_oe == 1'b0, "R4 data released", {31'd0, sd_out_oe}, 32'd0);
      pulse_start(8'hF0);  // R7 start during fault
      repeat (200) @(negedge clk);
      pulse_clr();         // R5 clear while line low
      repeat (2) @(negedge clk);
      chk(err_flag == 1'b1, "R5 clear refused while select low", {31'd0, err_flag}, 32'd1);
      sel_n = 1'b1;
      repeat (4) @(negedge clk);
      pulse_clr();
      chk(err_flag == 1'b0, "R5 clear accepted while select high", {31'd0, err_flag}, 32'd0);
      chk(sck_oe && sd_out_oe, "R5 enables restored", {30'd0, sck_oe, sd_out_oe}, 32'd3);
      begin
         int highs;
         highs = 0;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (sck_out) highs++;
         end
         chk(highs == 0, "R7 start during fault ignored", highs, 32'd0);
      end
      // R6 fresh byte after abort
      m_xfer(8'h96, 8'hE1);

      // R8 and R9 slave role
      ctl_master = 1'b0;
      repeat (4) @(negedge clk);
      chk(sck_oe == 1'b0, "R8 slave clock pin input", {31'd0, sck_oe}, 32'd0);
      chk(sd_out_oe == 1'b0, "R9 deselected data released", {31'd0, sd_out_oe}, 32'd0);
      pulse_start(8'h5C);
      for (int k = 0; k < 5; k++) begin
         repeat (8) @(negedge clk); sd_in = ~sd_in; sck_in = 1'b1;
         repeat (8) @(negedge clk); sck_in = 1'b0;
      end
      repeat (8) @(negedge clk);
      chk(sd_out_oe == 1'b0, "R9 still released after edges", {31'd0, sd_out_oe}, 32'd0);
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(sd_out_oe == 1'b1, "R8 selected slave drives data", {31'd0, sd_out_oe}, 32'd1);
      s_xfer(8'h5C, 8'h3A, 1'b0);  // R9 edges while deselected left no trace
      s_xfer(8'hE7, 8'h18, 1'b1);

      // R3 slave with select disabled and line high
      ctl_sel_en = 1'b0; sel_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(sd_out_oe == 1'b1, "R3 slave drives with select disabled", {31'd0, sd_out_oe}, 32'd1);
      s_xfer(8'h0F, 8'hF0, 1'b1);

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R10 one completion per byte", exp_q.size(), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule